// File: doc/BRIEF.md
# Gate Latency Collector and Read Latency Programmer

After the memory PHY has finished its gate training, this block masters a small register bus to gather the trained system-latency codes of each byte lane. From them it derives one latency value, which it folds into the read-data control setting of a half-rate memory controller. The lane count follows the configured data width, one lane per eight data bits. Every lane result word carries a 3-bit latency code for each of four ranks. A code of zero stands for a rank that was never trained and is left out of the result.

The largest trained code becomes the correction. If the trained codes do not all agree, a mismatch flag is raised. The controller runs at half the PHY rate, so the correction goes in with its least significant bit dropped. It is added to the latency already held in the controller register. That latency is split over a saturating primary field and an overflow field. The updated word goes to both data-path read-control registers, and a read-back of the second one closes the sequence.

Top module: `gl_latency_programmer`

## Requirements
- R1: While reset is held and after it is released, `done`, `mismatch` and `bus_req` are 0 until `start` is seen.
- R2: On `start` the block reads lane result words in ascending lane order at address `LANE_BASE + lane*LANE_STRIDE`. The lane count is `data_width/8`, limited to `NUM_LANES`. A lane count of zero skips the lane reads.
- R3: In each lane word, the rank r code sits at bits `3r+2:3r` for r = 0..3. Codes equal to zero are excluded. Minimum and maximum are taken over all remaining codes of all read lanes.
- R4: `mismatch` is 1 at `done` exactly when the minimum and the maximum nonzero codes differ. If no code is nonzero, `mismatch` is 0 and the correction is 0.
- R5: The existing latency is the sum of bits 7:4 and bits 11:8 of the word read from `RDCTL0_ADDR`.
- R6: The correction is the maximum code with bit 0 forced to 0.
- R7: Let the total be the existing latency plus the correction. If the total is 15 or less, bits 7:4 hold the total and bits 11:8 hold 0. Otherwise bits 7:4 hold 15 and bits 11:8 hold the total minus 15, capped at 15. All other bits keep their read value.
- R8: The updated word is written to `RDCTL0_ADDR` and then to `RDCTL1_ADDR`. A read of `RDCTL1_ADDR` follows, and after that `done` is high for exactly one cycle.
- R9: Once raised, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` hold steady until the cycle in which `bus_ack` is high. A transfer completes on a clock edge where both `bus_req` and `bus_ack` are high.
- R10: A `start` that arrives while a sequence is running is ignored, and no second sequence of transfers follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one collection and programming pass |
| data_width | input | WIDTH_W | Configured data width in bits |
| done | output | 1 | One-cycle pulse when the pass ends |
| mismatch | output | 1 | Trained codes were not all equal |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | Transfer is a write |
| bus_addr | output | ADDR_W | Transfer address |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid with bus_ack |
| bus_ack | input | 1 | Slave completes the current transfer |

## Verification
A corrupted running minimum or maximum does not show on the bus until the two register writes, several transfers later. It shows then as a wrong field split in the write data, or as a wrong `mismatch` value at the `done` pulse. A sequencer that is out of step shows at once: it puts a lane or register address out of order on the bus. The scoreboard flags it on the first transfer that differs. Lane-count limiting and the skipping of zero codes are exercised with lanes beyond the width that hold nonzero codes, so a miscount changes the written word.

// File: rtl/gl_pkg.sv
// Shared definitions for the gate latency programmer.
// Assumes the read-control word keeps its primary latency field at bits 7:4
// and its overflow field at bits 11:8, as the controller decodes them.
package gl_pkg;
    localparam int PRI_LSB = 4;
    localparam int OVF_LSB = 8;
    localparam int FLD_W   = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LANE,
        ST_CTLRD,
        ST_WR0,
        ST_WR1,
        ST_RBK,
        ST_DONE
    } gl_state_t;
endpackage

// File: rtl/gl_code_reduce.sv
// Reduces one lane result word to the minimum and maximum of its nonzero
// per-rank codes. Assumes rank r occupies bits r*CODE_W and up.
// Purely combinational.
module gl_code_reduce #(
    parameter int RANKS  = 4,
    parameter int CODE_W = 3
) (
    input  logic [RANKS*CODE_W-1:0] word,
    output logic                    any_valid,
    output logic [CODE_W-1:0]       code_min,
    output logic [CODE_W-1:0]       code_max
);
    logic [CODE_W-1:0] codes [RANKS];

    // Slice out one code field per rank
    for (genvar r = 0; r < RANKS; r++) begin : g_rank
        assign codes[r] = word[r*CODE_W +: CODE_W];
    end

    // Fold the nonzero codes into a min/max pair
    always_comb begin
        any_valid = 1'b0;
        code_min  = '1;
        code_max  = '0;
        for (int r = 0; r < RANKS; r++) begin
            if (codes[r] != '0) begin
                any_valid = 1'b1;
                if (codes[r] < code_min) code_min = codes[r];
                if (codes[r] > code_max) code_max = codes[r];
            end
        end
    end
endmodule

// File: rtl/gl_minmax_accum.sv
// Running minimum/maximum over the lanes of one pass.
// clr restarts the pass; upd merges one lane's result. Lanes without
// any trained rank leave the state unchanged.
module gl_minmax_accum #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd,
    input  logic              in_any,
    input  logic [CODE_W-1:0] in_min,
    input  logic [CODE_W-1:0] in_max,
    output logic              acc_any,
    output logic [CODE_W-1:0] acc_min,
    output logic [CODE_W-1:0] acc_max
);
    // Hold the running extremes of the trained codes
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_any <= 1'b0;
            acc_min <= '0;
            acc_max <= '0;
        end else if (upd && in_any) begin
            acc_any <= 1'b1;
            acc_min <= (!acc_any || in_min < acc_min) ? in_min : acc_min;
            acc_max <= (!acc_any || in_max > acc_max) ? in_max : acc_max;
        end
    end

    // R3: collected extremes stay ordered
    a_r3_min_le_max: assert property (@(posedge clk) disable iff (!rst_n)
        acc_any |-> (acc_min <= acc_max));
endmodule

// File: rtl/gl_latency_fold.sv
// Adds the half-rate correction to a read-control word and re-splits the
// sum over the saturating primary field and the overflow field.
// Assumes fields at gl_pkg::PRI_LSB and gl_pkg::OVF_LSB. Combinational.
module gl_latency_fold
    import gl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CODE_W = 3
) (
    input  logic [DATA_W-1:0] old_word,
    input  logic [CODE_W-1:0] max_code,
    output logic [DATA_W-1:0] new_word
);
    localparam int SUM_W = FLD_W + CODE_W;
    localparam logic [SUM_W-1:0] FMAX = SUM_W'((1 << FLD_W) - 1);

    logic [SUM_W-1:0] total;
    logic [SUM_W-1:0] over;

    // Sum the existing latency and the even-rounded correction, then split
    always_comb begin
        total = SUM_W'(old_word[PRI_LSB +: FLD_W])
              + SUM_W'(old_word[OVF_LSB +: FLD_W])
              + SUM_W'({max_code[CODE_W-1:1], 1'b0});
        over     = '0;
        new_word = old_word;
        if (total > FMAX) begin
            over = total - FMAX;
            if (over > FMAX) over = FMAX;
            new_word[PRI_LSB +: FLD_W] = FMAX[FLD_W-1:0];
            new_word[OVF_LSB +: FLD_W] = over[FLD_W-1:0];
        end else begin
            new_word[PRI_LSB +: FLD_W] = total[FLD_W-1:0];
            new_word[OVF_LSB +: FLD_W] = '0;
        end
        // R7: overflow carries a value only once the primary field is full
        a_r7_field_split: assert (new_word[OVF_LSB +: FLD_W] == '0
                                  || new_word[PRI_LSB +: FLD_W] == '1);
    end
endmodule

// File: rtl/gl_latency_programmer.sv
// Top: sequences the bus transfers of one pass. It reads each lane result,
// reads read-control register 0, writes the folded word to both
// read-control registers, reads register 1 back and pulses done.
// Assumes the slave holds bus_ack for exactly the completing cycle.
module gl_latency_programmer
    import gl_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 16,
    parameter int NUM_LANES = 4,
    parameter int RANKS     = 4,
    parameter int CODE_W    = 3,
    parameter int WIDTH_W   = 8,
    parameter logic [ADDR_W-1:0] LANE_BASE   = 'h0280,
    parameter logic [ADDR_W-1:0] LANE_STRIDE = 'h0080,
    parameter logic [ADDR_W-1:0] RDCTL0_ADDR = 'h0600,
    parameter logic [ADDR_W-1:0] RDCTL1_ADDR = 'h0608
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH_W-1:0] data_width,
    output logic               done,
    output logic               mismatch,
    output logic               bus_req,
    output logic               bus_we,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic [DATA_W-1:0]  bus_rdata,
    input  logic               bus_ack
);
    localparam int LCNT_W = $clog2(NUM_LANES + 1);

    gl_state_t         state;
    logic [LCNT_W-1:0] lane_idx;
    logic [LCNT_W-1:0] lane_cnt;
    logic [LCNT_W-1:0] lanes_req;
    logic [DATA_W-1:0] new_word_r;
    logic [DATA_W-1:0] fold_word;
    logic              mismatch_r;
    logic              red_any, acc_any;
    logic [CODE_W-1:0] red_min, red_max, acc_min, acc_max;
    logic [WIDTH_W-1:0] lanes_w;

    // Lane count from the data width, limited to the lanes present
    always_comb begin
        lanes_w = data_width >> 3;
        if (lanes_w > WIDTH_W'(NUM_LANES)) lanes_req = LCNT_W'(NUM_LANES);
        else                               lanes_req = LCNT_W'(lanes_w);
    end

    gl_code_reduce #(.RANKS(RANKS), .CODE_W(CODE_W)) u_reduce (
        .word      (bus_rdata[RANKS*CODE_W-1:0]),
        .any_valid (red_any),
        .code_min  (red_min),
        .code_max  (red_max)
    );

    gl_minmax_accum #(.CODE_W(CODE_W)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state == ST_IDLE && start),
        .upd     (state == ST_LANE && bus_ack),
        .in_any  (red_any),
        .in_min  (red_min),
        .in_max  (red_max),
        .acc_any (acc_any),
        .acc_min (acc_min),
        .acc_max (acc_max)
    );

    gl_latency_fold #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_fold (
        .old_word (bus_rdata),
        .max_code (acc_max),
        .new_word (fold_word)
    );

    // Pass sequencer: advances on each completed transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            lane_idx   <= '0;
            lane_cnt   <= '0;
            new_word_r <= '0;
            mismatch_r <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    lane_idx   <= '0;
                    lane_cnt   <= lanes_req;
                    mismatch_r <= 1'b0;
                    state      <= (lanes_req == '0) ? ST_CTLRD : ST_LANE;
                end
                ST_LANE: if (bus_ack) begin
                    if (lane_idx + LCNT_W'(1) == lane_cnt) state <= ST_CTLRD;
                    else lane_idx <= lane_idx + LCNT_W'(1);
                end
                ST_CTLRD: if (bus_ack) begin
                    new_word_r <= fold_word;
                    mismatch_r <= acc_any && (acc_min != acc_max);
                    state      <= ST_WR0;
                end
                ST_WR0:  if (bus_ack) state <= ST_WR1;
                ST_WR1:  if (bus_ack) state <= ST_RBK;
                ST_RBK:  if (bus_ack) state <= ST_DONE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Bus request decode from the sequencer state
    always_comb begin
        bus_req  = 1'b0;
        bus_we   = 1'b0;
        bus_addr = '0;
        case (state)
            ST_LANE: begin
                bus_req  = 1'b1;
                bus_addr = LANE_BASE + ADDR_W'(lane_idx) * LANE_STRIDE;
            end
            ST_CTLRD: begin bus_req = 1'b1; bus_addr = RDCTL0_ADDR; end
            ST_WR0:   begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = RDCTL0_ADDR; end
            ST_WR1:   begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = RDCTL1_ADDR; end
            ST_RBK:   begin bus_req = 1'b1; bus_addr = RDCTL1_ADDR; end
            default:  ;
        endcase
    end

    assign bus_wdata = new_word_r;
    assign done      = (state == ST_DONE);
    assign mismatch  = mismatch_r;

    // R9: a pending request holds its command until acknowledged
    a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)
                                   && $stable(bus_we) && $stable(bus_wdata)));

    // R8: the write to register 0 is followed by the same data to register 1
    a_r8_second_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && bus_we && bus_addr == RDCTL0_ADDR)
        |=> (bus_req && bus_we && bus_addr == RDCTL1_ADDR
             && bus_wdata == $past(bus_wdata)));

    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/tb_gl_latency_programmer.sv
`timescale 1ns/1ps
module tb_gl_latency_programmer;
    localparam logic [15:0] LBASE = 16'h0280;
    localparam logic [15:0] LSTR  = 16'h0080;
    localparam logic [15:0] RC0   = 16'h0600;
    localparam logic [15:0] RC1   = 16'h0608;

    typedef struct {
        logic        we;
        logic [15:0] addr;
        logic [31:0] data;
    } xfer_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  data_width = 8'd32;
    logic        done, mismatch, bus_req, bus_we, bus_ack;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;

    int tests = 0;
    int fails = 0;
    int done_cnt = 0;
    bit finished = 1'b0;
    logic exp_mis = 1'b0;
    xfer_t exp_q[$];

    // slave model state
    logic [31:0] lane_mem [4];
    logic [31:0] rdctl0, rdctl1;
    int wait_cfg = 0;
    int wcnt = 0;
    logic ack_r = 1'b0;
    logic [31:0] rdata_r = '0;

    always #2.5 clk = ~clk;

    gl_latency_programmer dut (
        .clk(clk), .rst_n(rst_n), .start(start), .data_width(data_width),
        .done(done), .mismatch(mismatch), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack)
    );

    assign bus_ack   = ack_r;
    assign bus_rdata = rdata_r;

    function automatic logic [31:0] slave_read(input logic [15:0] a);
        if (a == RC0) return rdctl0;
        if (a == RC1) return rdctl1;
        for (int i = 0; i < 4; i++)
            if (a == LBASE + 16'(i) * LSTR) return lane_mem[i];
        return 32'h0;
    endfunction

    // Register slave with programmable wait states
    always @(posedge clk) begin
        if (!rst_n) begin
            ack_r <= 1'b0;
            wcnt  <= 0;
        end else if (ack_r) begin
            ack_r <= 1'b0;
            wcnt  <= 0;
            if (bus_req && bus_we) begin
                if (bus_addr == RC0) rdctl0 <= bus_wdata;
                if (bus_addr == RC1) rdctl1 <= bus_wdata;
            end
        end else if (bus_req) begin
            if (wcnt >= wait_cfg) begin
                ack_r   <= 1'b1;
                rdata_r <= slave_read(bus_addr);
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
        end
    endtask

    function automatic xfer_t mk(input logic we, input logic [15:0] a,
                                 input logic [31:0] d);
        xfer_t x;
        x.we = we; x.addr = a; x.data = d;
        return x;
    endfunction

    // Monitor: pops expected transfers and checks the done pulse
    always @(negedge clk) begin
        if (rst_n && bus_req && bus_ack) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected transfer", 32'(bus_addr), 32'h0);
            end else begin
                xfer_t e;
                e = exp_q.pop_front();
                check(bus_addr == e.addr && bus_we == e.we,
                      "R2 R8 transfer address/direction",
                      {15'h0, bus_we, bus_addr}, {15'h0, e.we, e.addr});
                if (e.we)
                    check(bus_wdata == e.data, "R5 R6 R7 write data",
                          bus_wdata, e.data);
            end
        end
        if (rst_n && done) begin
            done_cnt++;
            check(mismatch == exp_mis, "R4 mismatch at done",
                  32'(mismatch), 32'(exp_mis));
        end
    end

    // Driver: loads the slave, pushes expected transfers, runs one pass
    task automatic run_case(input logic [7:0] w, input logic [31:0] l0,
                            input logic [31:0] l1, input logic [31:0] l2,
                            input logic [31:0] l3, input logic [31:0] ctl,
                            input int wt, input bit poke);
        int n, mn, mx, ex, tot, pri, ov, dc0;
        bit any;
        logic [31:0] nv;
        lane_mem[0] = l0; lane_mem[1] = l1; lane_mem[2] = l2; lane_mem[3] = l3;
        rdctl0 = ctl; rdctl1 = 32'hDEAD0000; wait_cfg = wt; data_width = w;
        n = int'(w) / 8;
        if (n > 4) n = 4;
        any = 1'b0; mn = 7; mx = 0;
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(mk(1'b0, LBASE + 16'(i) * LSTR, 32'h0));
            for (int r = 0; r < 4; r++) begin
                int c;
                c = int'((lane_mem[i] >> (3 * r)) & 32'h7);
                if (c != 0) begin
                    any = 1'b1;
                    if (c < mn) mn = c;
                    if (c > mx) mx = c;
                end
            end
        end
        exp_mis = any && (mn != mx);
        ex  = int'(ctl[7:4]) + int'(ctl[11:8]);
        tot = ex + (mx & 6);
        if (tot > 15) begin
            pri = 15; ov = tot - 15;
            if (ov > 15) ov = 15;
        end else begin
            pri = tot; ov = 0;
        end
        nv = ctl;
        nv[7:4]  = 4'(pri);
        nv[11:8] = 4'(ov);
        exp_q.push_back(mk(1'b0, RC0, 32'h0));
        exp_q.push_back(mk(1'b1, RC0, nv));
        exp_q.push_back(mk(1'b1, RC1, nv));
        exp_q.push_back(mk(1'b0, RC1, 32'h0));
        dc0 = done_cnt;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        for (int i = 0; i < 3000 && done_cnt == dc0; i++) @(negedge clk);
        repeat (15) @(negedge clk);
        check(done_cnt == dc0 + 1, "R8 R10 one done pulse per pass",
              32'(done_cnt - dc0), 32'h1);
        check(exp_q.size() == 0, "R2 R8 all expected transfers seen",
              32'(exp_q.size()), 32'h0);
        check(rdctl0 == nv, "R7 read-control 0 contents", rdctl0, nv);
        check(rdctl1 == nv, "R8 read-control 1 contents", rdctl1, nv);
        exp_q.delete();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4; i++) lane_mem[i] = '0;
        rdctl0 = '0; rdctl1 = '0;
        repeat (3) @(negedge clk);
        // R1: quiet during reset
        check(!done && !mismatch && !bus_req, "R1 outputs in reset",
              {29'h0, done, mismatch, bus_req}, 32'h0);
        @(negedge clk) rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!done && !mismatch && !bus_req, "R1 outputs after reset",
              {29'h0, done, mismatch, bus_req}, 32'h0);

        // R3 R6: uniform code 3 on rank 0, 12 + 2 = 14
        run_case(8'd32, 32'h3, 32'h3, 32'h3, 32'h3, 32'h000E00CE, 0, 1'b0);
        // R4 R7: mixed codes, max 5 -> +4, 12 + 4 = 16 -> 15 / 1
        run_case(8'd32, 32'h0000_0002 | (32'h5 << 3), 32'h4 << 6, 32'h0,
                 32'h2 << 9, 32'h000E00CE, 1, 1'b0);
        // R2: width 16 reads two lanes; lanes 2,3 hold code 7 and are unused
        run_case(8'd16, 32'h2 << 3, 32'h2, 32'h7, 32'h7 << 9,
                 32'h0000_0350, 2, 1'b0);
        // R4 R5: no trained rank, 5 + 3 = 8
        run_case(8'd32, 32'h0, 32'h0, 32'h0, 32'h0, 32'h1234_0350, 0, 1'b0);
        // R2: width 0 skips every lane read
        run_case(8'd0, 32'h7, 32'h7, 32'h7, 32'h7, 32'h0000_0240, 1, 1'b0);
        // R7: overflow cap, 15 + 15 + 6, upper bits preserved
        run_case(8'd32, 32'h7 << 9, 32'h7, 32'h7 << 3, 32'h7 << 6,
                 32'hA5A5_0FF3, 0, 1'b0);
        // R2: width 64 limited to four lanes, odd code 1 rounds to 0
        run_case(8'd64, 32'h1, 32'h1 << 3, 32'h1 << 6, 32'h1 << 9,
                 32'h0000_0070, 3, 1'b0);
        // R9 R10: long waits with a start pulse during the pass
        run_case(8'd32, 32'h6, 32'h6 << 3, 32'h6 << 6, 32'h6 << 9,
                 32'h0000_0A40, 4, 1'b1);
        // R3: a lane holding several nonzero ranks, max 4 and min 1
        run_case(8'd8, 32'h1 | (32'h4 << 3) | (32'h3 << 6), 32'h0, 32'h0,
                 32'h0, 32'h0000_0000, 0, 1'b0);
        finish_run();
    end
endmodule